// File: doc/BRIEF.md
# Decode-Stage Early Branch Redirect

This block sits in the decode stage of a pipeline and checks a bundle of up to `W` instructions each cycle, scanning them in the order the stage hands them on. An instruction that is both direct and unconditional has a target that is already known at decode. The block compares that target with the next PC that fetch predicted. On a mismatch it raises a redirect toward fetch. The redirect carries the corrected next PC, a taken bit and a kill boundary. Younger entries of the same thread in the bundle are killed, and forwarding stops after the redirecting instruction.

The `DS` parameter selects a delay-slot variant. In that variant a mispredicted branch normally keeps its delay-slot instruction. A squash is held per thread and issued when the next instruction of that thread is forwarded, which may happen in a later cycle. A branch that was predicted taken and whose delay slot is conditional squashes at once. An instruction that was predicted taken but is not a control instruction is reported as a fatal control mispredict. Three saturating counters track resolved branches, target mispredicts and control mispredicts. An instruction with no source registers is marked ready to issue as it is forwarded.

Top module: `dec_branch_redirect`

## Requirements
- R1: Only an instruction with both `in_direct_i` and `in_uncond_i` set, and no control mispredict, counts as resolved. Each one that is scanned adds one to `cnt_resolved_o`, and `cnt_tmiss_o` never exceeds `cnt_resolved_o`.
- R2: When a resolved instruction's target differs from its predicted PC, in the same cycle `redir_o`=1, `redir_tid_o` is its thread, `redir_seq_o` is its sequence number, `redir_pc_o` is its target, and `cnt_tmiss_o` rises by one at the next edge. This applies with `DS`=0, and with `DS`=1 under R6.
- R3: `redir_taken_o` is 1 exactly when the branch target differs from the branch PC plus `INSN_BYTES`.
- R4: Scanning runs from slot 0 upward. Valid slots are forwarded (`fwd_o`) up to and including the one that raises a redirect or an error, and no slot after it is forwarded. A later valid slot of the redirect's thread whose sequence number exceeds the boundary is set in `kill_o`. Any other unforwarded valid slot raises `hold_o`.
- R5: A valid instruction with the predicted-taken bit set and `in_ctrl_i`=0 sets `ctrl_err_o`, is forwarded, and stops forwarding after it without a redirect. `cnt_cmiss_o` rises by one at the next edge.
- R6: With `DS`=1, a mispredicted resolved branch that was predicted taken and has `in_cds_i`=1 redirects in the same cycle, using its own sequence number as the boundary.
- R7: With `DS`=1, any other mispredicted resolved branch raises no redirect. The next forwarded instruction of that thread, in the same or a later cycle, is forwarded, and `redir_o` is raised with boundary equal to the branch sequence number plus one, together with the branch's target and taken bit. Forwarding then stops.
- R8: `ready_o[i]` is 1 exactly when slot i is forwarded and `in_nosrc_i[i]`=1.
- R9: A held squash is cleared once it is issued. Setting `flush_i[t]` discards thread t's held squash in that same cycle and leaves the other threads' held squashes untouched.
- R10: The three counters saturate at 2^`CW`-1 and never wrap.
- R11: After reset the counters read zero and no squash is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | NTHR | External squash per thread; clears that thread's held squash |
| in_vld_i | input | W | Slot valid |
| in_tid_i | input | W x TW | Thread of each slot |
| in_seq_i | input | W x SW | Sequence number of each slot |
| in_pc_i | input | W x AW | PC of each slot |
| in_tgt_i | input | W x AW | Computed branch target of each slot |
| in_ppc_i | input | W x AW | Predicted next PC of each slot |
| in_ptk_i | input | W | Predicted-taken bit |
| in_ctrl_i | input | W | Instruction is a control instruction |
| in_direct_i | input | W | Control target is direct |
| in_uncond_i | input | W | Control is unconditional |
| in_cds_i | input | W | Delay slot is conditional |
| in_nosrc_i | input | W | Instruction has no source registers |
| fwd_o | output | W | Slot forwarded this cycle |
| kill_o | output | W | Slot killed by the redirect |
| ready_o | output | W | Forwarded slot is ready to issue |
| hold_o | output | 1 | A valid slot was neither forwarded nor killed |
| redir_o | output | 1 | Redirect and squash toward fetch |
| redir_tid_o | output | TW | Thread of the redirect |
| redir_seq_o | output | SW | Kill boundary sequence number |
| redir_pc_o | output | AW | Corrected next PC |
| redir_taken_o | output | 1 | Corrected branch is taken |
| ctrl_err_o | output | 1 | Non-control instruction predicted taken |
| cnt_resolved_o | output | CW | Resolved-branch count |
| cnt_tmiss_o | output | CW | Target-mispredict count |
| cnt_cmiss_o | output | CW | Control-mispredict count |

## Verification
The only state that can go wrong is the per-thread held squash and the counters. A stale or missing held squash appears at the ports in the first cycle in which that thread's next instruction is presented: as a redirect that should not be there, a missing one, or the wrong boundary. That cycle may be the same cycle or the one after the branch. A counter fault appears one edge after the event that updates it, as a wrong increment or a wrap past the saturation value. The redirect fields, kill mask and forward mask are combinational in the bundle, so a fault there is visible in the cycle the bundle is presented.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
   typedef struct packed {
      logic ctrl;
      logic direct;
      logic uncond;
   } dbr_flags_t;

   localparam int DBR_NCNT = 3;
   localparam int DBR_CNT_RES  = 0;
   localparam int DBR_CNT_TGT  = 1;
   localparam int DBR_CNT_CTRL = 2;
endpackage

// File: rtl/dbr_slot_eval.sv
module dbr_slot_eval
   import dbr_pkg::*;
#(
   parameter int AW         = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] tgt,
   input  logic [AW-1:0] ppc,
   input  logic          ptk,
   input  dbr_flags_t    flags,
   output logic          cerr,
   output logic          resolved,
   output logic          miss,
   output logic          taken
);
   assign cerr     = ptk & ~flags.ctrl;
   assign resolved = flags.direct & flags.uncond & ~cerr;
   assign miss     = resolved & (tgt != ppc);
   assign taken    = (tgt != (pc + AW'(INSN_BYTES)));
endmodule

// File: rtl/dbr_sat_cnt.sv
module dbr_sat_cnt #(
   parameter int CW = 16,
   parameter int IW = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [IW-1:0] inc,
   output logic [CW-1:0] cnt
);
   localparam logic [CW:0] MAXV = {1'b0, {CW{1'b1}}};

   logic [CW:0] sum;
   assign sum = {1'b0, cnt} + (CW+1)'(inc);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt <= '0;
      else         cnt <= (sum > MAXV) ? MAXV[CW-1:0] : sum[CW-1:0];
   end
endmodule

// File: rtl/dbr_scan.sv
module dbr_scan #(
   parameter int W    = 4,
   parameter int NTHR = 2,
   parameter int TW   = 1,
   parameter int SW   = 16,
   parameter int AW   = 32,
   parameter int IW   = 3,
   parameter bit DS   = 1'b0
) (
   input  logic [W-1:0]              vld,
   input  logic [W-1:0][TW-1:0]      tid,
   input  logic [W-1:0][SW-1:0]      seq,
   input  logic [W-1:0][AW-1:0]      tgt,
   input  logic [W-1:0]              resolved,
   input  logic [W-1:0]              miss,
   input  logic [W-1:0]              cerr,
   input  logic [W-1:0]              taken,
   input  logic [W-1:0]              ptk,
   input  logic [W-1:0]              cds,
   input  logic [NTHR-1:0]           pend_q,
   input  logic [NTHR-1:0][SW-1:0]   pseq_q,
   input  logic [NTHR-1:0][AW-1:0]   ptgt_q,
   input  logic [NTHR-1:0]           ptk_q,
   output logic [W-1:0]              fwd,
   output logic [W-1:0]              kill,
   output logic                      rv,
   output logic [TW-1:0]             rtid,
   output logic [SW-1:0]             rseq,
   output logic [AW-1:0]             rpc,
   output logic                      rtaken,
   output logic                      err,
   output logic [NTHR-1:0]           pend_d,
   output logic [NTHR-1:0][SW-1:0]   pseq_d,
   output logic [NTHR-1:0][AW-1:0]   ptgt_d,
   output logic [NTHR-1:0]           ptk_d,
   output logic [IW-1:0]             n_res,
   output logic [IW-1:0]             n_miss,
   output logic [IW-1:0]             n_cerr
);
   always_comb begin
      logic          stop;
      logic [TW-1:0] t;
      stop   = 1'b0;
      t      = '0;
      fwd    = '0;
      rv     = 1'b0;
      rtid   = '0;
      rseq   = '0;
      rpc    = '0;
      rtaken = 1'b0;
      err    = 1'b0;
      n_res  = '0;
      n_miss = '0;
      n_cerr = '0;
      pend_d = pend_q;
      pseq_d = pseq_q;
      ptgt_d = ptgt_q;
      ptk_d  = ptk_q;
      for (int i = 0; i < W; i++) begin
         if (vld[i] && !stop) begin
            fwd[i] = 1'b1;
            t      = tid[i];
            if (pend_d[t]) begin
               // deferred squash fires after the delay-slot instruction
               rv        = 1'b1;
               rtid      = t;
               rseq      = pseq_d[t];
               rpc       = ptgt_d[t];
               rtaken    = ptk_d[t];
               pend_d[t] = 1'b0;
               stop      = 1'b1;
            end else if (cerr[i]) begin
               err    = 1'b1;
               n_cerr = n_cerr + IW'(1);
               stop   = 1'b1;
            end else if (resolved[i]) begin
               n_res = n_res + IW'(1);
               if (miss[i]) begin
                  n_miss = n_miss + IW'(1);
                  if (!DS || (ptk[i] && cds[i])) begin
                     rv     = 1'b1;
                     rtid   = t;
                     rseq   = seq[i];
                     rpc    = tgt[i];
                     rtaken = taken[i];
                     stop   = 1'b1;
                  end else begin
                     pend_d[t] = 1'b1;
                     pseq_d[t] = seq[i] + SW'(1);
                     ptgt_d[t] = tgt[i];
                     ptk_d[t]  = taken[i];
                  end
               end
            end
         end
      end
      for (int j = 0; j < W; j++) begin
         kill[j] = rv && vld[j] && !fwd[j] && (tid[j] == rtid) && (seq[j] > rseq);
      end
   end
endmodule

// File: rtl/dec_branch_redirect.sv
module dec_branch_redirect
   import dbr_pkg::*;
#(
   parameter int W          = 4,
   parameter int NTHR       = 2,
   parameter int TW         = (NTHR > 1) ? $clog2(NTHR) : 1,
   parameter int SW         = 16,
   parameter int AW         = 32,
   parameter int CW         = 16,
   parameter int INSN_BYTES = 4,
   parameter bit DS         = 1'b0
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [NTHR-1:0]         flush_i,
   input  logic [W-1:0]            in_vld_i,
   input  logic [W-1:0][TW-1:0]    in_tid_i,
   input  logic [W-1:0][SW-1:0]    in_seq_i,
   input  logic [W-1:0][AW-1:0]    in_pc_i,
   input  logic [W-1:0][AW-1:0]    in_tgt_i,
   input  logic [W-1:0][AW-1:0]    in_ppc_i,
   input  logic [W-1:0]            in_ptk_i,
   input  logic [W-1:0]            in_ctrl_i,
   input  logic [W-1:0]            in_direct_i,
   input  logic [W-1:0]            in_uncond_i,
   input  logic [W-1:0]            in_cds_i,
   input  logic [W-1:0]            in_nosrc_i,
   output logic [W-1:0]            fwd_o,
   output logic [W-1:0]            kill_o,
   output logic [W-1:0]            ready_o,
   output logic                    hold_o,
   output logic                    redir_o,
   output logic [TW-1:0]           redir_tid_o,
   output logic [SW-1:0]           redir_seq_o,
   output logic [AW-1:0]           redir_pc_o,
   output logic                    redir_taken_o,
   output logic                    ctrl_err_o,
   output logic [CW-1:0]           cnt_resolved_o,
   output logic [CW-1:0]           cnt_tmiss_o,
   output logic [CW-1:0]           cnt_cmiss_o
);
   localparam int IW = $clog2(W + 1);

   // elaboration-time parameter checks
   if (W < 1)                         begin : g_chk_w   $error("W must be at least 1"); end
   if (IW > CW)                       begin : g_chk_cw  $error("CW too narrow for one bundle"); end
   if ((NTHR & (NTHR - 1)) != 0)      begin : g_chk_thr $error("NTHR must be a power of two"); end
   if (TW < 1 || (1 << TW) < NTHR)    begin : g_chk_tw  $error("TW cannot index NTHR threads"); end
   if (INSN_BYTES < 1)                begin : g_chk_ib  $error("INSN_BYTES must be positive"); end

   logic [W-1:0] cerr, resolved, miss, taken;

   for (genvar s = 0; s < W; s++) begin : g_slot
      dbr_flags_t fl;
      assign fl = '{ctrl: in_ctrl_i[s], direct: in_direct_i[s], uncond: in_uncond_i[s]};
      dbr_slot_eval #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_eval (
         .pc       (in_pc_i[s]),
         .tgt      (in_tgt_i[s]),
         .ppc      (in_ppc_i[s]),
         .ptk      (in_ptk_i[s]),
         .flags    (fl),
         .cerr     (cerr[s]),
         .resolved (resolved[s]),
         .miss     (miss[s]),
         .taken    (taken[s])
      );
   end

   logic [NTHR-1:0]         pend_q, pend_d, ptk_q, ptk_d;
   logic [NTHR-1:0][SW-1:0] pseq_q, pseq_d;
   logic [NTHR-1:0][AW-1:0] ptgt_q, ptgt_d;
   logic [DBR_NCNT-1:0][IW-1:0] incs;
   logic [DBR_NCNT-1:0][CW-1:0] cnts;

   dbr_scan #(.W(W), .NTHR(NTHR), .TW(TW), .SW(SW), .AW(AW), .IW(IW), .DS(DS)) u_scan (
      .vld      (in_vld_i),
      .tid      (in_tid_i),
      .seq      (in_seq_i),
      .tgt      (in_tgt_i),
      .resolved (resolved),
      .miss     (miss),
      .cerr     (cerr),
      .taken    (taken),
      .ptk      (in_ptk_i),
      .cds      (in_cds_i),
      .pend_q   (pend_q & ~flush_i),
      .pseq_q   (pseq_q),
      .ptgt_q   (ptgt_q),
      .ptk_q    (ptk_q),
      .fwd      (fwd_o),
      .kill     (kill_o),
      .rv       (redir_o),
      .rtid     (redir_tid_o),
      .rseq     (redir_seq_o),
      .rpc      (redir_pc_o),
      .rtaken   (redir_taken_o),
      .err      (ctrl_err_o),
      .pend_d   (pend_d),
      .pseq_d   (pseq_d),
      .ptgt_d   (ptgt_d),
      .ptk_d    (ptk_d),
      .n_res    (incs[DBR_CNT_RES]),
      .n_miss   (incs[DBR_CNT_TGT]),
      .n_cerr   (incs[DBR_CNT_CTRL])
   );

   // held squash per thread; only the delay-slot variant keeps it
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         pseq_q <= '0;
         ptgt_q <= '0;
         ptk_q  <= '0;
      end else if (DS) begin
         pend_q <= pend_d;
         pseq_q <= pseq_d;
         ptgt_q <= ptgt_d;
         ptk_q  <= ptk_d;
      end
   end

   for (genvar c = 0; c < DBR_NCNT; c++) begin : g_cnt
      dbr_sat_cnt #(.CW(CW), .IW(IW)) u_cnt (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .inc    (incs[c]),
         .cnt    (cnts[c])
      );
   end

   assign cnt_resolved_o = cnts[DBR_CNT_RES];
   assign cnt_tmiss_o    = cnts[DBR_CNT_TGT];
   assign cnt_cmiss_o    = cnts[DBR_CNT_CTRL];
   assign ready_o        = fwd_o & in_nosrc_i;
   assign hold_o         = |(in_vld_i & ~fwd_o & ~kill_o);
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
   parameter int W  = 4,
   parameter int CW = 16
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic [W-1:0]  fwd_o,
   input logic [W-1:0]  kill_o,
   input logic [W-1:0]  ready_o,
   input logic          redir_o,
   input logic          ctrl_err_o,
   input logic [CW-1:0] cnt_resolved_o,
   input logic [CW-1:0] cnt_tmiss_o,
   input logic [CW-1:0] cnt_cmiss_o
);
   AST_KILL_NEEDS_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni) (|kill_o) |-> redir_o); // R4
   AST_FWD_KILL_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni) (fwd_o & kill_o) == '0); // R4
   AST_READY_ONLY_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni) (ready_o & ~fwd_o) == '0); // R8
   AST_REDIRECT_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni) redir_o |-> (|fwd_o)); // R2
   AST_ERR_EXCLUDES_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni) ctrl_err_o |-> !redir_o); // R5
   AST_MISS_WITHIN_RESOLVED: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_tmiss_o <= cnt_resolved_o); // R1
   AST_RESOLVED_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> cnt_resolved_o >= $past(cnt_resolved_o)); // R10
   AST_CMISS_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> cnt_cmiss_o >= $past(cnt_cmiss_o)); // R10
endmodule

bind dec_branch_redirect dbr_checker #(.W(W), .CW(CW)) u_dbr_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .fwd_o          (fwd_o),
   .kill_o         (kill_o),
   .ready_o        (ready_o),
   .redir_o        (redir_o),
   .ctrl_err_o     (ctrl_err_o),
   .cnt_resolved_o (cnt_resolved_o),
   .cnt_tmiss_o    (cnt_tmiss_o),
   .cnt_cmiss_o    (cnt_cmiss_o)
);

// File: tb/test_dec_branch_redirect.sv
module test_dec_branch_redirect;
   localparam int W = 4, NTHR = 2, TW = 1, SW = 8, AW = 16, CW = 4, IB = 4;

   logic clk = 1'b0;
   logic rst_a_n = 1'b0, rst_b_n = 1'b0;
   logic [NTHR-1:0] flush;
   logic [W-1:0] vld, ptk, ctl, dir, unc, cds, nos;
   logic [W-1:0][TW-1:0] tid;
   logic [W-1:0][SW-1:0] seq;
   logic [W-1:0][AW-1:0] pc, tg, pp;

   logic [W-1:0] a_fwd, a_kill, a_rdy, b_fwd, b_kill, b_rdy;
   logic a_hold, a_rv, a_tk, a_err, b_hold, b_rv, b_tk, b_err;
   logic [TW-1:0] a_rt, b_rt;
   logic [SW-1:0] a_rs, b_rs;
   logic [AW-1:0] a_rp, b_rp;
   logic [CW-1:0] a_cr, a_ct, a_cc, b_cr, b_ct, b_cc;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dec_branch_redirect #(.W(W), .NTHR(NTHR), .TW(TW), .SW(SW), .AW(AW), .CW(CW),
                         .INSN_BYTES(IB), .DS(1'b0)) i_dec_branch_redirect (
      .clk_i(clk), .rst_ni(rst_a_n), .flush_i(flush), .in_vld_i(vld), .in_tid_i(tid),
      .in_seq_i(seq), .in_pc_i(pc), .in_tgt_i(tg), .in_ppc_i(pp), .in_ptk_i(ptk),
      .in_ctrl_i(ctl), .in_direct_i(dir), .in_uncond_i(unc), .in_cds_i(cds), .in_nosrc_i(nos),
      .fwd_o(a_fwd), .kill_o(a_kill), .ready_o(a_rdy), .hold_o(a_hold), .redir_o(a_rv),
      .redir_tid_o(a_rt), .redir_seq_o(a_rs), .redir_pc_o(a_rp), .redir_taken_o(a_tk),
      .ctrl_err_o(a_err), .cnt_resolved_o(a_cr), .cnt_tmiss_o(a_ct), .cnt_cmiss_o(a_cc));

   dec_branch_redirect #(.W(W), .NTHR(NTHR), .TW(TW), .SW(SW), .AW(AW), .CW(CW),
                         .INSN_BYTES(IB), .DS(1'b1)) i_dec_branch_redirect_ds (
      .clk_i(clk), .rst_ni(rst_b_n), .flush_i(flush), .in_vld_i(vld), .in_tid_i(tid),
      .in_seq_i(seq), .in_pc_i(pc), .in_tgt_i(tg), .in_ppc_i(pp), .in_ptk_i(ptk),
      .in_ctrl_i(ctl), .in_direct_i(dir), .in_uncond_i(unc), .in_cds_i(cds), .in_nosrc_i(nos),
      .fwd_o(b_fwd), .kill_o(b_kill), .ready_o(b_rdy), .hold_o(b_hold), .redir_o(b_rv),
      .redir_tid_o(b_rt), .redir_seq_o(b_rs), .redir_pc_o(b_rp), .redir_taken_o(b_tk),
      .ctrl_err_o(b_err), .cnt_resolved_o(b_cr), .cnt_tmiss_o(b_ct), .cnt_cmiss_o(b_cc));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clr();
      vld = '0; ptk = '0; ctl = '0; dir = '0; unc = '0; cds = '0; nos = '0;
      tid = '0; seq = '0; pc = '0; tg = '0; pp = '0; flush = '0;
   endtask

   task automatic put(input int s, input int t, input int sq, input int p, input int g, input int q,
                      input bit pk, input bit c, input bit d, input bit u, input bit cd, input bit ns);
      vld[s] = 1'b1; tid[s] = TW'(t); seq[s] = SW'(sq); pc[s] = AW'(p); tg[s] = AW'(g); pp[s] = AW'(q);
      ptk[s] = pk; ctl[s] = c; dir[s] = d; unc[s] = u; cds[s] = cd; nos[s] = ns;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int e_res, e_miss;
      clr();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_a_n = 1'b1; rst_b_n = 1'b1;
      #2;
      // R11 reset state
      chk("R11", "a resolved cnt", 32'(a_cr), 0);
      chk("R11", "a tmiss cnt", 32'(a_ct), 0);
      chk("R11", "a cmiss cnt", 32'(a_cc), 0);
      chk("R11", "a idle redirect", 32'(a_rv), 0);

      // R1 R2 R3 R8 R10: sweep single-slot vectors on the non-delay-slot variant
      e_res = 0; e_miss = 0;
      for (int k = 0; k < 64; k++) begin
         bit c, d, u, mt, ns, nr;
         int p, g, q;
         {c, d, u, mt, ns, nr} = 6'(k);
         p = 16'h100 + k * 16;
         g = nr ? p + IB : p + 16'h40;
         q = mt ? g : g + 8;
         @(negedge clk);
         clr();
         put(0, 0, k, p, g, q, 1'b0, c, d, u, 1'b0, ns);
         #2;
         chk("R2", "redirect on target mismatch", 32'(a_rv), 32'(d & u & ~mt));
         chk("R8", "ready flag", 32'(a_rdy), 32'(ns));
         chk("R4", "single slot forwarded", 32'(a_fwd), 1);
         if (d && u && !mt) begin
            chk("R2", "boundary seq", 32'(a_rs), 32'(k));
            chk("R2", "next pc", 32'(a_rp), 32'(g));
            chk("R3", "taken bit", 32'(a_tk), 32'(!nr));
         end
         if (d && u) e_res = (e_res < 15) ? e_res + 1 : 15;
         if (d && u && !mt) e_miss = (e_miss < 15) ? e_miss + 1 : 15;
         @(posedge clk); #1;
         chk("R10", "resolved cnt saturating", 32'(a_cr), 32'(e_res));
         chk("R1", "tmiss cnt", 32'(a_ct), 32'(e_miss));
      end

      // R4 kill of younger same-thread entries, hold of others
      @(negedge clk);
      clr();
      put(0, 0, 10, 16'h200, 0, 0, 0, 0, 0, 0, 0, 0);
      put(1, 0, 11, 16'h204, 16'h300, 16'h208, 0, 1, 1, 1, 0, 0);
      put(2, 1, 12, 16'h208, 0, 0, 0, 0, 0, 0, 0, 0);
      put(3, 0, 13, 16'h20c, 0, 0, 0, 0, 0, 0, 0, 0);
      #2;
      chk("R4", "fwd mask", 32'(a_fwd), 32'b0011);
      chk("R4", "kill mask", 32'(a_kill), 32'b1000);
      chk("R4", "hold", 32'(a_hold), 1);
      chk("R2", "bundle boundary", 32'(a_rs), 11);
      chk("R2", "bundle thread", 32'(a_rt), 0);
      chk("R3", "bundle taken", 32'(a_tk), 1);
      @(posedge clk); #1;
      chk("R2", "tmiss incremented", 32'(a_ct), 32'(e_miss + 1));

      // R5 predicted-taken non-control instruction
      @(negedge clk);
      clr();
      put(0, 0, 20, 16'h280, 0, 0, 1, 0, 0, 0, 0, 0);
      put(1, 0, 21, 16'h284, 0, 0, 0, 0, 0, 0, 0, 0);
      #2;
      chk("R5", "ctrl err", 32'(a_err), 1);
      chk("R5", "no redirect", 32'(a_rv), 0);
      chk("R5", "fwd stops", 32'(a_fwd), 32'b0001);
      chk("R5", "hold", 32'(a_hold), 1);
      @(posedge clk); #1;
      chk("R5", "cmiss cnt", 32'(a_cc), 1);

      // delay-slot variant: fresh reset
      @(negedge clk); clr(); rst_b_n = 1'b0;
      @(negedge clk); rst_b_n = 1'b1; #2;
      chk("R11", "ds resolved cnt", 32'(b_cr), 0);

      // R6 immediate squash with conditional delay slot
      @(negedge clk);
      clr();
      put(0, 0, 20, 16'h400, 16'h500, 16'h404, 1, 1, 1, 1, 1, 0);
      put(1, 0, 21, 16'h404, 0, 0, 0, 0, 0, 0, 0, 0);
      #2;
      chk("R6", "immediate redirect", 32'(b_rv), 1);
      chk("R6", "own boundary", 32'(b_rs), 20);
      chk("R6", "fwd", 32'(b_fwd), 32'b0001);
      chk("R6", "kill", 32'(b_kill), 32'b0010);

      // R7 deferred squash within one bundle
      @(negedge clk);
      clr();
      put(0, 0, 30, 16'h600, 16'h700, 16'h604, 0, 1, 1, 1, 0, 0);
      put(1, 0, 31, 16'h604, 0, 0, 0, 0, 0, 0, 0, 1);
      put(2, 0, 32, 16'h608, 0, 0, 0, 0, 0, 0, 0, 0);
      #2;
      chk("R7", "deferred redirect", 32'(b_rv), 1);
      chk("R7", "boundary plus one", 32'(b_rs), 31);
      chk("R7", "target", 32'(b_rp), 32'h700);
      chk("R7", "fwd incl delay slot", 32'(b_fwd), 32'b0011);
      chk("R7", "kill", 32'(b_kill), 32'b0100);
      chk("R8", "ds ready", 32'(b_rdy), 32'b0010);

      // R7 deferred squash across cycles
      @(negedge clk);
      clr();
      put(0, 0, 40, 16'h800, 16'h880, 16'h804, 0, 1, 1, 1, 0, 0);
      #2;
      chk("R7", "no redirect at branch", 32'(b_rv), 0);
      @(negedge clk);
      clr();
      put(0, 1, 50, 16'h900, 0, 0, 0, 0, 0, 0, 0, 0);
      put(1, 0, 41, 16'h804, 0, 0, 0, 0, 0, 0, 0, 0);
      put(2, 0, 42, 16'h808, 0, 0, 0, 0, 0, 0, 0, 0);
      #2;
      chk("R7", "late redirect", 32'(b_rv), 1);
      chk("R7", "late boundary", 32'(b_rs), 41);
      chk("R7", "late thread", 32'(b_rt), 0);
      chk("R3", "late taken", 32'(b_tk), 1);
      chk("R7", "late fwd", 32'(b_fwd), 32'b0011);
      chk("R7", "late kill", 32'(b_kill), 32'b0100);
      @(negedge clk);
      clr();
      put(0, 0, 43, 16'h80c, 0, 0, 0, 0, 0, 0, 0, 0);
      #2;
      chk("R9", "cleared after issue", 32'(b_rv), 0);

      // R9 external flush of the owning thread
      @(negedge clk);
      clr();
      put(0, 0, 60, 16'ha00, 16'hb00, 16'ha04, 0, 1, 1, 1, 0, 0);
      @(negedge clk);
      clr();
      flush = 2'b01;
      put(0, 0, 61, 16'ha04, 0, 0, 0, 0, 0, 0, 0, 0);
      #2;
      chk("R9", "flush clears", 32'(b_rv), 0);
      chk("R9", "flush fwd", 32'(b_fwd), 32'b0001);
      @(negedge clk);
      clr();
      put(0, 0, 62, 16'ha08, 0, 0, 0, 0, 0, 0, 0, 0);
      #2;
      chk("R9", "stays cleared", 32'(b_rv), 0);

      // R9 flush of another thread leaves the held squash
      @(negedge clk);
      clr();
      put(0, 0, 70, 16'hc00, 16'hd00, 16'hc04, 0, 1, 1, 1, 0, 0);
      @(negedge clk);
      clr();
      flush = 2'b10;
      put(0, 0, 71, 16'hc04, 0, 0, 0, 0, 0, 0, 0, 0);
      #2;
      chk("R9", "other flush keeps", 32'(b_rv), 1);
      chk("R9", "kept boundary", 32'(b_rs), 71);
      @(posedge clk); #1;
      chk("R1", "ds resolved cnt", 32'(b_cr), 5);

      @(negedge clk); clr();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule